// File: doc/BRIEF.md
# Special Register and Condition Flag File

This block holds the control state that sits beside the general registers of a small 32-bit processor. It has sixteen 32-bit special-register slots, eight single-bit condition and control flags, and a program counter. Software reaches the slots through one indexed combinational read port and one indexed write port. The execute stage updates individual flags through a separate per-flag enable and value pair, with no need to go through the indexed port.

Some slots do not behave as plain storage. Three slots always read as zero. One slot always reads a fixed version number. Writes to these four slots are dropped. Two other slots are aliases of one condition-code word. A read of either alias returns the stored upper 24 bits of slot 5, with the eight live flags packed into the low byte. A write to either alias loads all eight flags from that byte and stores the full word into both alias slots.

The program counter has its own load port, and its least significant bit is always cleared on a write. The block has no state machine. Each cycle, the index decoder sorts the write into one of three named kinds: DROP (discarded), ALIAS (flag fan-out plus a dual store) or PLAIN (a single store). It sorts the read into one of four named sources: ZERO, CONST, PACKED or STORED.

Top module: `sreg_flag_file`

## Requirements
- R1: A read of index 0, 4 or 8 returns 0.
- R2: A read of index 1 returns the version constant, which is 10 by default.
- R3: A write to index 0, 1, 4 or 8 changes no state. No slot, flag or read value is affected.
- R4: A read of index 5 or 13 returns the stored bits 31..8 of slot 5, with the live flags in bits 7..0 in this order: C at bit 0, V at 1, Z at 2, N at 3, X at 4, I at 5, U at 6, P at 7. The `flags` output uses the same bit order.
- R5: A write to index 5 or 13 loads flag k from bit k of the written word (k = 0..7) at the next edge. It also stores the full word into both slot 5 and slot 13.
- R6: A write to any other index stores the word in that slot only.
- R7: A program counter load stores the value with bit 0 forced to 0.
- R8: When an alias write (index 5 or 13) and an execute-stage flag update fall in the same cycle, the flags take the written byte.
- R9: With no alias write in the cycle, each flag whose execute enable is 1 takes the execute value at the next edge, and every other flag holds its value.
- R10: A synchronous active-high reset clears every slot, every flag and the program counter to 0.
- R11: The read port is combinational. In the cycle of a write it still shows the value from before that write (no bypass).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Read index |
| rd_data | output | 32 | Combinational read data |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| exu_flag_we | input | 8 | Per-flag update enables from the execute stage |
| exu_flag_val | input | 8 | Per-flag update values from the execute stage |
| flags | output | 8 | Live flags, same bit order as the packed byte |
| pc_we | input | 1 | Program counter load strobe |
| pc_wdata | input | 32 | Program counter load value |
| pc | output | 32 | Program counter |

## Verification
The read source is checked in two ways. Distinct per-slot patterns are written to every plain slot and read back, which tells single-slot storage apart from aliasing. The constant and dropped slots are then written with all-ones, which exposes any write that leaks into storage. Alias writes use bytes with an asymmetric bit mix and then a partial execute-stage mask, so a swapped flag position or a stale packed byte shows up. Same-cycle collisions of alias writes with execute updates, together with a read taken during a write, separate write priority and the no-bypass rule from their opposites.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int FLAG_N   = 8;
    localparam int FLG_C    = 0;
    localparam int FLG_V    = 1;
    localparam int FLG_Z    = 2;
    localparam int FLG_N    = 3;
    localparam int FLG_X    = 4;
    localparam int FLG_I    = 5;
    localparam int FLG_U    = 6;
    localparam int FLG_P    = 7;

    localparam int IDX_ZERO_A    = 0;
    localparam int IDX_VERSION   = 1;
    localparam int IDX_ZERO_B    = 4;
    localparam int IDX_CCR       = 5;
    localparam int IDX_ZERO_C    = 8;
    localparam int IDX_CCR_ALIAS = 13;

    typedef enum logic [1:0] {
        SEL_ZERO   = 2'd0,
        SEL_CONST  = 2'd1,
        SEL_PACKED = 2'd2,
        SEL_STORED = 2'd3
    } rd_sel_e;

    typedef enum logic [1:0] {
        WK_DROP  = 2'd0,
        WK_ALIAS = 2'd1,
        WK_PLAIN = 2'd2
    } wr_kind_e;

    function automatic rd_sel_e classify_read(input int idx);
        if (idx == IDX_ZERO_A || idx == IDX_ZERO_B || idx == IDX_ZERO_C)
            return SEL_ZERO;
        else if (idx == IDX_VERSION)
            return SEL_CONST;
        else if (idx == IDX_CCR || idx == IDX_CCR_ALIAS)
            return SEL_PACKED;
        else
            return SEL_STORED;
    endfunction

    function automatic wr_kind_e classify_write(input int idx);
        if (idx == IDX_ZERO_A || idx == IDX_ZERO_B ||
            idx == IDX_ZERO_C || idx == IDX_VERSION)
            return WK_DROP;
        else if (idx == IDX_CCR || idx == IDX_CCR_ALIAS)
            return WK_ALIAS;
        else
            return WK_PLAIN;
    endfunction

endpackage

// File: rtl/sreg_index_decode.sv
module sreg_index_decode
    import sreg_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output rd_sel_e          rd_sel,
    output wr_kind_e         wr_kind,
    output logic             wr_alias,
    output logic             wr_plain
);

    always_comb begin
        rd_sel  = classify_read(int'(rd_idx));
        wr_kind = wr_en ? classify_write(int'(wr_idx)) : WK_DROP;
    end

    always_comb begin
        wr_alias = 1'b0;
        wr_plain = 1'b0;
        unique case (wr_kind)
            WK_DROP:  ;
            WK_ALIAS: wr_alias = 1'b1;
            WK_PLAIN: wr_plain = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/sreg_flag_bank.sv
module sreg_flag_bank #(
    parameter int FLAGS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_load,
    input  logic [FLAGS-1:0] sw_val,
    input  logic [FLAGS-1:0] ex_we,
    input  logic [FLAGS-1:0] ex_val,
    output logic [FLAGS-1:0] flag_q
);

    for (genvar k = 0; k < FLAGS; k++) begin : g_flag
        logic nxt;
        always_comb begin
            if (sw_load)
                nxt = sw_val[k];
            else if (ex_we[k])
                nxt = ex_val[k];
            else
                nxt = flag_q[k];
        end
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[k] <= 1'b0;
            else
                flag_q[k] <= nxt;
        end
    end

endmodule

// File: rtl/sreg_store.sv
module sreg_store
    import sreg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_alias,
    input  logic              wr_plain,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_stored,
    output logic [DATA_W-1:0] ccr_word
);

    logic [DATA_W-1:0] slot_q [NUM_REGS];

    for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
        localparam wr_kind_e KIND = classify_write(s);
        logic hit;
        if (KIND == WK_ALIAS) begin : g_alias
            assign hit = wr_alias;
        end else if (KIND == WK_PLAIN) begin : g_plain
            assign hit = wr_plain && (wr_idx == IDX_W'(s));
        end else begin : g_drop
            assign hit = 1'b0;
        end
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[s] <= '0;
            else if (hit)
                slot_q[s] <= wr_data;
        end
    end

    assign rd_stored = slot_q[rd_idx];
    assign ccr_word  = slot_q[IDX_CCR];

endmodule

// File: rtl/sreg_pc.sv
module sreg_pc #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] pc_q
);

    localparam logic [DATA_W-1:0] EVEN_MASK = ~DATA_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (load)
            pc_q <= load_val & EVEN_MASK;
    end

endmodule

// File: rtl/sreg_flag_file.sv
module sreg_flag_file
    import sreg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_REGS   = 16,
    parameter int VERSION_ID = 10,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_N-1:0] exu_flag_we,
    input  logic [FLAG_N-1:0] exu_flag_val,
    output logic [FLAG_N-1:0] flags,
    input  logic              pc_we,
    input  logic [DATA_W-1:0] pc_wdata,
    output logic [DATA_W-1:0] pc
);

    rd_sel_e           rd_sel;
    wr_kind_e          wr_kind;
    logic              wr_alias;
    logic              wr_plain;
    logic [DATA_W-1:0] rd_stored;
    logic [DATA_W-1:0] ccr_word;

    sreg_index_decode #(.IDX_W(IDX_W)) u_dec (
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_sel   (rd_sel),
        .wr_kind  (wr_kind),
        .wr_alias (wr_alias),
        .wr_plain (wr_plain)
    );

    sreg_flag_bank #(.FLAGS(FLAG_N)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .sw_load (wr_alias),
        .sw_val  (wr_data[FLAG_N-1:0]),
        .ex_we   (exu_flag_we),
        .ex_val  (exu_flag_val),
        .flag_q  (flags)
    );

    sreg_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_alias  (wr_alias),
        .wr_plain  (wr_plain),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_stored (rd_stored),
        .ccr_word  (ccr_word)
    );

    sreg_pc #(.DATA_W(DATA_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (pc_we),
        .load_val (pc_wdata),
        .pc_q     (pc)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_ZERO:   rd_data = '0;
            SEL_CONST:  rd_data = DATA_W'(VERSION_ID);
            SEL_PACKED: rd_data = {ccr_word[DATA_W-1:FLAG_N], flags};
            SEL_STORED: rd_data = rd_stored;
            default:    rd_data = '0;
        endcase
    end

    logic unused_kind;
    assign unused_kind = ^wr_kind;

endmodule

// File: rtl/sreg_flag_file_chk.sv
module sreg_flag_file_chk
    import sreg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_REGS   = 16,
    parameter int VERSION_ID = 10,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [FLAG_N-1:0] exu_flag_we,
    input logic [FLAG_N-1:0] exu_flag_val,
    input logic [FLAG_N-1:0] flags,
    input logic              pc_we,
    input logic [DATA_W-1:0] pc_wdata,
    input logic [DATA_W-1:0] pc
);

    logic alias_wr;
    assign alias_wr = wr_en && (wr_idx == IDX_W'(IDX_CCR) || wr_idx == IDX_W'(IDX_CCR_ALIAS));

    AST_ZERO_SLOTS: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_W'(IDX_ZERO_A) || rd_idx == IDX_W'(IDX_ZERO_B) || rd_idx == IDX_W'(IDX_ZERO_C))
        |-> rd_data == '0); // R1

    AST_VERSION_READ: assert property (@(posedge clk) disable iff (rst)
        rd_idx == IDX_W'(IDX_VERSION) |-> rd_data == DATA_W'(VERSION_ID)); // R2

    AST_PACKED_LOW: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_W'(IDX_CCR) || rd_idx == IDX_W'(IDX_CCR_ALIAS))
        |-> rd_data[FLAG_N-1:0] == flags); // R4

    AST_ALIAS_WINS: assert property (@(posedge clk) disable iff (rst)
        alias_wr |=> flags == $past(wr_data[FLAG_N-1:0])); // R8

    AST_EXU_MERGE: assert property (@(posedge clk) disable iff (rst)
        !alias_wr |=> flags == (($past(flags) & ~$past(exu_flag_we)) |
                                ($past(exu_flag_val) & $past(exu_flag_we)))); // R9

    AST_PC_EVEN: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> pc == {$past(pc_wdata[DATA_W-1:1]), 1'b0}); // R7

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc)); // R7

endmodule

bind sreg_flag_file sreg_flag_file_chk #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .VERSION_ID(VERSION_ID)
) u_chk (.*);

// File: tb/sreg_flag_file_bench.sv
`timescale 1ns/1ps
module sreg_flag_file_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic [7:0]  exu_flag_we;
    logic [7:0]  exu_flag_val;
    logic [7:0]  flags;
    logic        pc_we;
    logic [31:0] pc_wdata;
    logic [31:0] pc;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_reg [16];
    logic [7:0]  m_flags;
    logic [31:0] m_pc;

    always #2.5 clk = ~clk;

    sreg_flag_file u_sreg_flag_file (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .exu_flag_we(exu_flag_we), .exu_flag_val(exu_flag_val), .flags(flags),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .pc(pc)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int i);
        if (i == 0 || i == 4 || i == 8) return 32'd0;
        if (i == 1) return 32'd10;
        if (i == 5 || i == 13) return {m_reg[5][31:8], m_flags};
        return m_reg[i];
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_flags = '0;
        m_pc = '0;
    endfunction

    task automatic model_write(input int i, input logic [31:0] d);
        if (i == 0 || i == 1 || i == 4 || i == 8) return;
        if (i == 5 || i == 13) begin
            m_reg[5] = d; m_reg[13] = d; m_flags = d[7:0];
        end else begin
            m_reg[i] = d;
        end
    endtask

    task automatic sw_write(input int i, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(i, d);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #0.5;
            check(tag, $sformatf("read idx %0d", i), rd_data, model_read(i));
        end
        check(tag, "flags", {24'd0, flags}, {24'd0, m_flags});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();  // R10, R1, R2
        check_all("R10");
        check("R10", "pc", pc, 32'd0);
        rd_idx = 4'd1; #0.5; check("R2", "version", rd_data, 32'd10);
        rd_idx = 4'd8; #0.5; check("R1", "zero idx 8", rd_data, 32'd0);
    endtask

    task automatic t_plain();  // R6
        for (int i = 0; i < 16; i++)
            if (!(i inside {0, 1, 4, 5, 8, 13}))
                sw_write(i, 32'h1000_0001 * (i + 1) ^ 32'hC3A5_0F0F);
        check_all("R6");
    endtask

    task automatic t_drop();  // R3
        sw_write(0, 32'hFFFF_FFFF);
        sw_write(1, 32'hFFFF_FFFF);
        sw_write(4, 32'hFFFF_FFFF);
        sw_write(8, 32'hFFFF_FFFF);
        check_all("R3");
    endtask

    task automatic t_alias();  // R5, R4
        sw_write(5, 32'hA5C3_F05A);
        check("R5", "flags from idx5 write", {24'd0, flags}, 32'h0000_005A);
        check_all("R5");
        sw_write(13, 32'h1234_5681);
        rd_idx = 4'd5; #0.5;
        check("R5", "idx5 after idx13 write", rd_data, 32'h1234_5681);
        rd_idx = 4'd13; #0.5;
        check("R4", "idx13 packed", rd_data, 32'h1234_5681);
    endtask

    task automatic t_exu();  // R9, R4
        @(negedge clk);
        exu_flag_we = 8'b0000_1111; exu_flag_val = 8'b0000_0110;
        @(negedge clk);
        exu_flag_we = '0;
        m_flags = (m_flags & 8'hF0) | 8'h06;
        check("R9", "partial exu update", {24'd0, flags}, {24'd0, m_flags});
        rd_idx = 4'd5; #0.5;
        check("R4", "packed after exu", rd_data, {24'h123456, m_flags});
        rd_idx = 4'd13; #0.5;
        check("R4", "alias packed after exu", rd_data, {24'h123456, m_flags});
    endtask

    task automatic t_collide();  // R8
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hDEAD_BE3C;
        exu_flag_we = 8'hFF; exu_flag_val = 8'hC3;
        @(negedge clk);
        wr_en = 1'b0; exu_flag_we = '0;
        model_write(13, 32'hDEAD_BE3C);
        check("R8", "sw over exu", {24'd0, flags}, 32'h0000_003C);
    endtask

    task automatic t_pc();  // R7
        @(negedge clk); pc_we = 1'b1; pc_wdata = 32'h8000_1235;
        @(negedge clk); pc_we = 1'b0;
        check("R7", "odd load", pc, 32'h8000_1234);
        @(negedge clk); pc_we = 1'b1; pc_wdata = 32'h0000_0FFE;
        @(negedge clk); pc_we = 1'b0;
        check("R7", "even load", pc, 32'h0000_0FFE);
        @(negedge clk);
        check("R7", "hold", pc, 32'h0000_0FFE);
    endtask

    task automatic t_nobypass();  // R11
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd7; wr_data = 32'h7777_0000; rd_idx = 4'd7;
        #0.5;
        check("R11", "old value during write", rd_data, m_reg[7]);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(7, 32'h7777_0000);
        #0.5;
        check("R11", "new value after edge", rd_data, 32'h7777_0000);
    endtask

    initial begin
        rst = 1'b1; rd_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        exu_flag_we = '0; exu_flag_val = '0; pc_we = 1'b0; pc_wdata = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_drop();
        t_alias();
        t_exu();
        t_collide();
        t_pc();
        t_nobypass();
        do_reset();
        check_all("R10");
        check("R10", "pc after reset", pc, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #50000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule